// File: doc/BRIEF.md
# Optical Disc Start-Up Sequencer

This block brings a disc drive from reset to a state where it can read data. It walks a fixed list of steps. The pickup is first driven to the inner track. Then the laser is switched on and the lens is swept while the block waits for a focus lock. After that the focus loop is closed and the disc is spun. The tracking and spindle loops are closed next. Finally the table of contents is read and the pickup seeks the start of the data area, where it parks. Each step drives its own enable lines to the servo and motor logic, and moves on when the matching completion input is seen.

Every step that waits on an input is guarded by a cycle timeout taken from the `timeout_i` port. The lens sweep is instead bounded by a fixed number of up/down sweeps. When a guard expires, every enable is removed. The block then holds a fault state that reports the step that failed. A status LED shows progress: a slow flicker during bring-up, a fast flicker while the table of contents is read, steady on after a fault, and off once parked. A one-cycle start pulse restarts the whole sequence from the sled step, from any state.

Top module: `disc_bringup_seq`

## Requirements
- R1: After reset is released the block is in the sled step: `step_o`=1, `sled_en_o`=1, and every other enable, `done_o`, `error_o` and `fail_step_o` are 0.
- R2: In the sled step (code 1) the laser stays off. The cycle after `inner_i` is sampled high, the block enters the laser step (code 2): `laser_en_o`=1 and `sled_en_o`=0. One cycle later it enters the focus search step (code 3).
- R3: In focus search `focus_srch_o`=1. The lens sweeps in periods of SWEEP_LEN (default 16) cycles. `lens_up_o` is 1 in the first SWEEP_LEN/2 cycles of each sweep and 0 in the rest, counting from the first cycle of the step.
- R4: The focus servo stays off during the search. The cycle after `focus_ok_i` is sampled high in the search, `focus_servo_o` and `spindle_en_o` go to 1 (spin step, code 4) and `focus_srch_o` goes to 0.
- R5: One cycle after the spin step, `track_servo_o` goes to 1 (code 5). One cycle later `spindle_servo_o` goes to 1 (code 6). The block then waits for `spin_lock_i` before it enters the table-of-contents step (code 7).
- R6: `toc_done_i` moves the block from step 7 to the seek step (code 8). `seek_done_i` then moves it to the park step (code 9), where `done_o`=1, `laser_en_o`, `focus_servo_o`, `spindle_en_o`, `track_servo_o` and `spindle_servo_o` are 1, and `sled_en_o` and `focus_srch_o` are 0, until the next start.
- R7: If `focus_ok_i` is never high during the search, the block enters the fault step after MAX_SWEEPS*SWEEP_LEN+1 search cycles (49 by default). It then reports `fail_step_o`=3 and never reaches step 7.
- R8: In steps 1, 6, 7 and 8, if the completion input stays low for `timeout_i`+1 cycles, the block enters the fault step (code 10). There `error_o`=1, every enable is 0, and `fail_step_o` holds the code of the step that timed out. The fault step ignores completion inputs.
- R9: The LED toggles every 8 cycles in steps 1 to 6 and 8, and every 2 cycles in step 7. It is steadily 1 in the fault step and 0 in the park step.
- R10: A cycle with `start_i` high sends the block to the sled step from any state, clears `error_o`, `done_o` and `fail_step_o`, and restarts the step timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Restart pulse |
| timeout_i | input | 16 | Per-step timeout in cycles |
| inner_i | input | 1 | Pickup at inner track |
| focus_ok_i | input | 1 | Focus lock detected |
| spin_lock_i | input | 1 | Spindle locked |
| toc_done_i | input | 1 | Table of contents read |
| seek_done_i | input | 1 | Data area start reached |
| sled_en_o | output | 1 | Sled motor drive enable |
| laser_en_o | output | 1 | Laser enable |
| focus_srch_o | output | 1 | Focus search sweep active |
| lens_up_o | output | 1 | Sweep direction, 1 = up |
| focus_servo_o | output | 1 | Focus loop closed |
| spindle_en_o | output | 1 | Disc rotation enable |
| track_servo_o | output | 1 | Tracking loop closed |
| spindle_servo_o | output | 1 | Spindle loop closed |
| led_o | output | 1 | Status LED |
| done_o | output | 1 | Parked at data start |
| error_o | output | 1 | Fault step active |
| step_o | output | 4 | Current step code |
| fail_step_o | output | 4 | Code of the step that failed, 0 if none |

## Verification
The hardest case to reach is a timeout or a success that lands on the exact cycle at the edge of a step's window. The completion inputs are only meaningful relative to when the block entered each step. The stimulus therefore watches `step_o` and raises each completion input a random number of cycles after its step begins, with delays drawn around the timeout value and around the sweep budget. A bench function predicts both the final step and the total cycle count. Directed runs cover focus failure, a sled timeout, LED rates and restart from fault and park.

// File: rtl/disc_seq_pkg.sv
package disc_seq_pkg;
  typedef enum logic [3:0] {
    ST_SLED  = 4'd1,
    ST_LASER = 4'd2,
    ST_FSRCH = 4'd3,
    ST_SPIN  = 4'd4,
    ST_TRACK = 4'd5,
    ST_SPSRV = 4'd6,
    ST_TOC   = 4'd7,
    ST_SEEK  = 4'd8,
    ST_PARK  = 4'd9,
    ST_FAULT = 4'd10
  } step_e;

  typedef enum logic [1:0] {
    LED_OFF  = 2'd0,
    LED_ON   = 2'd1,
    LED_SLOW = 2'd2,
    LED_FAST = 2'd3
  } led_mode_e;
endpackage

// File: rtl/seq_step_timer.sv
module seq_step_timer #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic [TMO_W-1:0] limit_i,
  output logic             expired_o
);
  logic [TMO_W-1:0] cnt_q;
  logic [TMO_W-1:0] cnt_d;
  logic             cnt_en;
  logic             sat;

  assign sat    = &cnt_q;
  assign cnt_en = clr_i | (run_i & ~sat);

  always_comb begin
    if (clr_i) cnt_d = '0;
    else       cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired_o = run_i & (cnt_q >= limit_i);

  // R8: a cleared timer starts the next step from zero
  p_clear_restarts_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr_i) |-> (cnt_q == '0));
endmodule

// File: rtl/seq_focus_sweep.sv
module seq_focus_sweep #(
  parameter int SWEEP_LEN  = 16,
  parameter int MAX_SWEEPS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic run_i,
  output logic lens_up_o,
  output logic exhausted_o
);
  localparam int PW = $clog2(SWEEP_LEN);
  localparam int NW = $clog2(MAX_SWEEPS + 1);
  localparam logic [PW-1:0] POS_LAST = PW'(SWEEP_LEN - 1);
  localparam logic [NW-1:0] N_LAST   = NW'(MAX_SWEEPS);

  logic [PW-1:0] pos_q, pos_d;
  logic [NW-1:0] nsw_q, nsw_d;
  logic          sw_en;

  assign exhausted_o = run_i & (nsw_q == N_LAST);
  assign sw_en       = clr_i | (run_i & (nsw_q != N_LAST));

  always_comb begin
    pos_d = pos_q;
    nsw_d = nsw_q;
    if (clr_i) begin
      pos_d = '0;
      nsw_d = '0;
    end else if (pos_q == POS_LAST) begin
      pos_d = '0;
      nsw_d = nsw_q + 1'b1;
    end else begin
      pos_d = pos_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      nsw_q <= '0;
    end else if (sw_en) begin
      pos_q <= pos_d;
      nsw_q <= nsw_d;
    end
  end

  assign lens_up_o = run_i & (32'(pos_q) < SWEEP_LEN / 2);

  // R7: the sweep count never passes its budget
  p_sweep_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    32'(nsw_q) <= MAX_SWEEPS);
  // R3: direction turns down at the middle of a sweep
  p_turn_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !clr_i && 32'(pos_q) == SWEEP_LEN / 2 - 1 && !exhausted_o)
      |=> (clr_i || !lens_up_o || !run_i));
endmodule

// File: rtl/seq_led_flicker.sv
module seq_led_flicker
  import disc_seq_pkg::*;
#(
  parameter int SLOW_LOG2 = 3,
  parameter int FAST_LOG2 = 1
) (
  input  logic      clk,
  input  logic      rst_n,
  input  led_mode_e mode_i,
  output logic      led_o
);
  localparam int CW = SLOW_LOG2 + 1;

  logic [CW-1:0] cnt_q;
  logic          cnt_en;

  assign cnt_en = (mode_i == LED_SLOW) | (mode_i == LED_FAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_q + 1'b1;
  end

  always_comb begin
    unique case (mode_i)
      LED_SLOW: led_o = cnt_q[SLOW_LOG2];
      LED_FAST: led_o = cnt_q[FAST_LOG2];
      LED_ON:   led_o = 1'b1;
      default:  led_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/disc_bringup_seq.sv
module disc_bringup_seq
  import disc_seq_pkg::*;
#(
  parameter int TMO_W      = 16,
  parameter int SWEEP_LEN  = 16,
  parameter int MAX_SWEEPS = 3,
  parameter int SLOW_LOG2  = 3,
  parameter int FAST_LOG2  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [TMO_W-1:0] timeout_i,
  input  logic             inner_i,
  input  logic             focus_ok_i,
  input  logic             spin_lock_i,
  input  logic             toc_done_i,
  input  logic             seek_done_i,
  output logic             sled_en_o,
  output logic             laser_en_o,
  output logic             focus_srch_o,
  output logic             lens_up_o,
  output logic             focus_servo_o,
  output logic             spindle_en_o,
  output logic             track_servo_o,
  output logic             spindle_servo_o,
  output logic             led_o,
  output logic             done_o,
  output logic             error_o,
  output logic [3:0]       step_o,
  output logic [3:0]       fail_step_o
);
  step_e     state_q, state_d;
  step_e     fail_q;
  logic      step_chg;
  logic      to_fault;
  logic      fail_en;
  logic      wait_st;
  logic      tmr_exp;
  logic      sw_exh;
  logic      sw_run;
  led_mode_e led_mode;

  assign wait_st = (state_q == ST_SLED) | (state_q == ST_SPSRV) |
                   (state_q == ST_TOC)  | (state_q == ST_SEEK);
  assign sw_run  = (state_q == ST_FSRCH);

  seq_step_timer #(.TMO_W(TMO_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (step_chg),
    .run_i     (wait_st),
    .limit_i   (timeout_i),
    .expired_o (tmr_exp)
  );

  seq_focus_sweep #(.SWEEP_LEN(SWEEP_LEN), .MAX_SWEEPS(MAX_SWEEPS)) u_sweep (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_i       (step_chg),
    .run_i       (sw_run),
    .lens_up_o   (lens_up_o),
    .exhausted_o (sw_exh)
  );

  // next-step decision
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_SLED:  if (inner_i)          state_d = ST_LASER;
                else if (tmr_exp)     state_d = ST_FAULT;
      ST_LASER:                       state_d = ST_FSRCH;
      ST_FSRCH: if (focus_ok_i)       state_d = ST_SPIN;
                else if (sw_exh)      state_d = ST_FAULT;
      ST_SPIN:                        state_d = ST_TRACK;
      ST_TRACK:                       state_d = ST_SPSRV;
      ST_SPSRV: if (spin_lock_i)      state_d = ST_TOC;
                else if (tmr_exp)     state_d = ST_FAULT;
      ST_TOC:   if (toc_done_i)       state_d = ST_SEEK;
                else if (tmr_exp)     state_d = ST_FAULT;
      ST_SEEK:  if (seek_done_i)      state_d = ST_PARK;
                else if (tmr_exp)     state_d = ST_FAULT;
      default:                        state_d = state_q;
    endcase
    if (start_i) state_d = ST_SLED;
  end

  assign step_chg = start_i | (state_d != state_q);
  assign to_fault = (state_d == ST_FAULT) & (state_q != ST_FAULT);
  assign fail_en  = start_i | to_fault;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_SLED;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       fail_q <= step_e'(4'd0);
    else if (fail_en) fail_q <= start_i ? step_e'(4'd0) : state_q;
  end

  // enable decode from the registered step
  always_comb begin
    sled_en_o       = 1'b0;
    laser_en_o      = 1'b0;
    focus_srch_o    = 1'b0;
    focus_servo_o   = 1'b0;
    spindle_en_o    = 1'b0;
    track_servo_o   = 1'b0;
    spindle_servo_o = 1'b0;
    done_o          = 1'b0;
    error_o         = 1'b0;
    led_mode        = LED_SLOW;
    unique case (state_q)
      ST_SLED:  sled_en_o = 1'b1;
      ST_LASER: laser_en_o = 1'b1;
      ST_FSRCH: begin
        laser_en_o   = 1'b1;
        focus_srch_o = 1'b1;
      end
      ST_SPIN: begin
        laser_en_o    = 1'b1;
        focus_servo_o = 1'b1;
        spindle_en_o  = 1'b1;
      end
      ST_TRACK: begin
        laser_en_o    = 1'b1;
        focus_servo_o = 1'b1;
        spindle_en_o  = 1'b1;
        track_servo_o = 1'b1;
      end
      ST_SPSRV, ST_TOC, ST_SEEK, ST_PARK: begin
        laser_en_o      = 1'b1;
        focus_servo_o   = 1'b1;
        spindle_en_o    = 1'b1;
        track_servo_o   = 1'b1;
        spindle_servo_o = 1'b1;
        if (state_q == ST_TOC)  led_mode = LED_FAST;
        if (state_q == ST_PARK) begin
          led_mode = LED_OFF;
          done_o   = 1'b1;
        end
      end
      ST_FAULT: begin
        error_o  = 1'b1;
        led_mode = LED_ON;
      end
      default: led_mode = LED_ON;
    endcase
  end

  seq_led_flicker #(.SLOW_LOG2(SLOW_LOG2), .FAST_LOG2(FAST_LOG2)) u_led (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode_i (led_mode),
    .led_o  (led_o)
  );

  assign step_o      = state_q;
  assign fail_step_o = fail_q;

  // R2: laser comes on only after the inner track was reported
  p_laser_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(laser_en_o) |-> $past(inner_i));
  // R4: focus loop closes only after focus lock was reported
  p_focus_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(focus_servo_o) |-> $past(focus_ok_i));
  // R5: spindle loop only with tracking, rotation and focus closed
  p_loop_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    spindle_servo_o |-> (track_servo_o && spindle_en_o && focus_servo_o));
  // R6: parked state keeps the loops closed and the LED dark
  p_park_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (spindle_servo_o && !led_o && !error_o));
  // R8: a fault drops every enable
  p_fault_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    error_o |-> !(sled_en_o | laser_en_o | focus_srch_o | focus_servo_o |
                  spindle_en_o | track_servo_o | spindle_servo_o));
  // R8: the reported step is the one active just before the fault
  p_fault_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(error_o) |-> (fail_step_o == $past(step_o)));
  // R10: a start pulse always returns to the sled step
  p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (sled_en_o && !error_o && !done_o && fail_step_o == 4'd0));
endmodule

// File: tb/disc_bringup_seq_tb_top.sv
module disc_bringup_seq_tb_top;
  localparam int SWEEP_LEN  = 16;
  localparam int MAX_SWEEPS = 3;
  localparam int FS_CYC     = SWEEP_LEN * MAX_SWEEPS;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [15:0] timeout_i;
  logic        inner_i, focus_ok_i, spin_lock_i, toc_done_i, seek_done_i;
  logic        sled_en_o, laser_en_o, focus_srch_o, lens_up_o, focus_servo_o;
  logic        spindle_en_o, track_servo_o, spindle_servo_o, led_o, done_o, error_o;
  logic [3:0]  step_o, fail_step_o;

  int n_chk  = 0;
  int n_fail = 0;
  int n_cyc  = 0;

  always #2 clk = ~clk;

  disc_bringup_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .timeout_i(timeout_i),
    .inner_i(inner_i), .focus_ok_i(focus_ok_i), .spin_lock_i(spin_lock_i),
    .toc_done_i(toc_done_i), .seek_done_i(seek_done_i),
    .sled_en_o(sled_en_o), .laser_en_o(laser_en_o), .focus_srch_o(focus_srch_o),
    .lens_up_o(lens_up_o), .focus_servo_o(focus_servo_o), .spindle_en_o(spindle_en_o),
    .track_servo_o(track_servo_o), .spindle_servo_o(spindle_servo_o),
    .led_o(led_o), .done_o(done_o), .error_o(error_o),
    .step_o(step_o), .fail_step_o(fail_step_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick;
    @(negedge clk);
  endtask

  function automatic int en_sum();
    return int'(sled_en_o) + int'(laser_en_o) + int'(focus_srch_o) + int'(focus_servo_o) +
           int'(spindle_en_o) + int'(track_servo_o) + int'(spindle_servo_o);
  endfunction

  task automatic clear_inputs;
    start_i = 0; inner_i = 0; focus_ok_i = 0; spin_lock_i = 0;
    toc_done_i = 0; seek_done_i = 0;
  endtask

  task automatic do_reset(input int tmo);
    clear_inputs();
    timeout_i = 16'(tmo);
    rst_n = 0;
    repeat (3) tick();
    rst_n = 1;
  endtask

  // expected final step code and cycle count from the requirements
  function automatic void predict(input int t, input int din, input int dok,
                                  input int dlk, input int dtoc, input int dsk,
                                  output int code, output int cyc);
    cyc = 0;
    if (din > t) begin code = 1; cyc = t + 1; return; end
    cyc += din + 1 + 1;
    if (dok > FS_CYC) begin code = 3; cyc += FS_CYC + 1; return; end
    cyc += dok + 1 + 2;
    if (dlk > t) begin code = 6; cyc += t + 1; return; end
    cyc += dlk + 1;
    if (dtoc > t) begin code = 7; cyc += t + 1; return; end
    cyc += dtoc + 1;
    if (dsk > t) begin code = 8; cyc += t + 1; return; end
    cyc += dsk + 1;
    code = 9;
  endfunction

  always @(posedge clk) begin
    n_cyc++;
    if (n_cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=0", n_cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int prev, tog, bad, toc_seen;
    void'($urandom(32'd20517));
    tick();

    // ---------------- directed: full bring-up ----------------
    do_reset(1000);
    chk("R1", "step", step_o, 1);
    chk("R1", "sled_en", sled_en_o, 1);
    chk("R1", "other enables", en_sum(), 1);
    chk("R1", "done/error", int'(done_o) + int'(error_o), 0);
    chk("R1", "fail_step", fail_step_o, 0);
    bad = 0;
    repeat (5) begin tick(); if (!sled_en_o || laser_en_o) bad++; end
    chk("R2", "laser off while sled runs", bad, 0);
    inner_i = 1; tick(); inner_i = 0;
    chk("R2", "laser on", laser_en_o, 1);
    chk("R2", "sled off", sled_en_o, 0);
    tick();
    chk("R2", "search step", step_o, 3);
    chk("R3", "focus_srch", focus_srch_o, 1);
    bad = 0;
    for (int k = 0; k < 20; k++) begin
      if (int'(lens_up_o) != (((k % SWEEP_LEN) < SWEEP_LEN / 2) ? 1 : 0)) bad++;
      if (focus_servo_o) bad++;
      tick();
    end
    chk("R3", "lens direction per cycle", bad, 0);
    focus_ok_i = 1; tick(); focus_ok_i = 0;
    chk("R4", "focus servo", focus_servo_o, 1);
    chk("R4", "spindle en", spindle_en_o, 1);
    chk("R4", "search off", focus_srch_o, 0);
    chk("R5", "tracking not yet", track_servo_o, 0);
    tick();
    chk("R5", "tracking on", track_servo_o, 1);
    chk("R5", "spindle servo not yet", spindle_servo_o, 0);
    tick();
    chk("R5", "spindle servo on", spindle_servo_o, 1);
    repeat (3) tick();
    chk("R5", "waits for lock", step_o, 6);
    spin_lock_i = 1; tick(); spin_lock_i = 0;
    chk("R5", "toc step", step_o, 7);
    prev = led_o; tog = 0;
    repeat (16) begin tick(); if (int'(led_o) != prev) tog++; prev = led_o; end
    chk("R9", "fast flicker toggles in 16", tog, 8);
    toc_done_i = 1; tick(); toc_done_i = 0;
    chk("R6", "seek step", step_o, 8);
    seek_done_i = 1; tick(); seek_done_i = 0;
    chk("R6", "park step", step_o, 9);
    chk("R6", "done", done_o, 1);
    chk("R6", "enables in park", en_sum(), 5);
    chk("R6", "sled/search off", int'(sled_en_o) + int'(focus_srch_o), 0);
    chk("R9", "led off in park", led_o, 0);
    repeat (5) tick();
    chk("R6", "park held", int'(done_o) + int'(step_o == 4'd9), 2);
    start_i = 1; tick(); start_i = 0;
    chk("R10", "restart from park step", step_o, 1);
    chk("R10", "restart done cleared", done_o, 0);
    chk("R10", "restart laser off", laser_en_o, 0);

    // ---------------- directed: sled timeout ----------------
    do_reset(20);
    bad = 0; tog = 0; prev = led_o;
    for (int k = 0; k <= 20; k++) begin
      if (step_o != 4'd1) bad++;
      if (k >= 1 && k <= 16 && int'(led_o) != prev) tog++;
      prev = led_o;
      tick();
    end
    chk("R8", "sled waits timeout+1 cycles", bad, 0);
    chk("R9", "slow flicker toggles in 16", tog, 2);
    chk("R8", "fault step", step_o, 10);
    chk("R8", "error", error_o, 1);
    chk("R8", "fail_step sled", fail_step_o, 1);
    chk("R8", "enables dropped", en_sum(), 0);
    bad = 0;
    inner_i = 1; spin_lock_i = 1; toc_done_i = 1; seek_done_i = 1;
    repeat (30) begin tick(); if (!led_o) bad++; if (step_o != 4'd10) bad++; end
    clear_inputs();
    chk("R9", "steady led in fault", bad, 0);
    chk("R8", "fault ignores inputs", fail_step_o, 1);
    start_i = 1; tick(); start_i = 0;
    chk("R10", "restart from fault", step_o, 1);
    chk("R10", "error cleared", int'(error_o) + int'(fail_step_o), 0);

    // ---------------- directed: focus never found ----------------
    do_reset(1000);
    inner_i = 1; tick(); tick(); inner_i = 0;
    chk("R7", "search entered", step_o, 3);
    bad = 0; toc_seen = 0;
    for (int k = 0; k <= FS_CYC; k++) begin
      if (step_o != 4'd3) bad++;
      tick();
    end
    repeat (10) begin if (step_o == 4'd7) toc_seen++; tick(); end
    chk("R7", "search length", bad, 0);
    chk("R7", "fault after sweeps", step_o, 10);
    chk("R7", "fail_step search", fail_step_o, 3);
    chk("R7", "toc never reached", toc_seen, 0);
    chk("R7", "led steady", led_o, 1);

    // ---------------- random delays around the limits ----------------
    for (int it = 0; it < 40; it++) begin
      int t, din, dok, dlk, dtoc, dsk, ecode, ecyc, cur, cnt, n, s;
      t    = 4 + int'($urandom % 30);
      din  = int'($urandom % (t + 3));
      dok  = int'($urandom % (FS_CYC + 6));
      dlk  = int'($urandom % (t + 3));
      dtoc = int'($urandom % (t + 3));
      dsk  = int'($urandom % (t + 3));
      if (it == 0) begin din = t; dok = FS_CYC; dlk = t; dtoc = t; dsk = t; end
      if (it == 1) begin din = 0; dok = 0; dlk = 0; dtoc = 0; dsk = 0; end
      if (it == 2) begin din = 0; dok = 0; dlk = 0; dtoc = t + 1; end
      predict(t, din, dok, dlk, dtoc, dsk, ecode, ecyc);
      do_reset(t);
      cur = -1; cnt = 0; n = 0;
      while (n < 3000) begin
        s = int'(step_o);
        if (s == 9 || s == 10) break;
        if (s != cur) begin cur = s; cnt = 0; end
        inner_i     = (s == 1) && (cnt >= din);
        focus_ok_i  = (s == 3) && (cnt >= dok);
        spin_lock_i = (s == 6) && (cnt >= dlk);
        toc_done_i  = (s == 7) && (cnt >= dtoc);
        seek_done_i = (s == 8) && (cnt >= dsk);
        tick();
        cnt++; n++;
      end
      clear_inputs();
      chk("R6 R8", "random final step", step_o, (ecode == 9) ? 9 : 10);
      chk("R6 R8", "random cycle count", n, ecyc);
      chk("R8", "random fail_step", fail_step_o, (ecode == 9) ? 0 : ecode);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule